// File: doc/BRIEF.md
# Triggered Multichannel Scan Sequencer

This block paces a multichannel A/D acquisition. Software arms it with a start pulse. The first trigger pulse that arrives while it is armed opens an acquisition. An optional delay, counted in timebase ticks, may come first. The block then runs a programmed number of scans. Each scan converts every enabled channel once, lowest index first, one sample interval apart. Successive scans begin one scan interval apart. The block drives a scan-start strobe, a conversion strobe with its channel index, a scan-busy flag and an acquisition-busy flag. The converter, sample storage and data movement are separate blocks.

The controller is a six-state machine:

- `SQ_IDLE` moves to `SQ_ARMED` on start, provided at least one channel is enabled.
- `SQ_ARMED` moves on a trigger, to `SQ_LAUNCH` when the delay is zero and to `SQ_DELAY` otherwise.
- `SQ_DELAY` moves to `SQ_LAUNCH` when the delay expires.
- `SQ_LAUNCH` emits the first scan start. It then moves to `SQ_SCAN` while channels remain in the scan. When the scan's only conversion has been made, it moves on exactly as the last conversion of a scan does.
- `SQ_SCAN` emits one conversion per sample interval. After the last conversion of a scan it moves to `SQ_GAP` if scans remain. Otherwise it moves to `SQ_ARMED` if retriggers remain, and to `SQ_IDLE` if none remain.
- `SQ_GAP` launches the next scan in place once both the scan timer and the sample timer have expired.
- An abort forces `SQ_IDLE` from every state.

Top module: `scan_seq_top`

## Requirements
- R1: After reset, all strobes and busy flags are 0. While the block is idle, a trigger pulse causes no conversion; only a start pulse, given with at least one channel enabled, arms it.
- R2: With a zero delay, the first scan start and the first conversion appear together one clock after the clock in which an armed trigger is sampled.
- R3: With a delay of D, the first scan start comes D ticks later than in R2. With a tick in every clock, that is D+1 clocks after the trigger.
- R4: Within a scan, every enabled channel (bit i of the enable vector is channel i) is converted once, in ascending index order. Conversions are spaced by the effective sample interval in ticks, and the scan start always coincides with the first conversion of the scan.
- R5: A sample interval below 100 is replaced by 100, and the clamp flag is high exactly while the programmed value is below 100.
- R6: Successive scan starts are spaced by the larger of the scan interval and the number of enabled channels times the sample interval.
- R7: Each trigger yields exactly the programmed number of scans; a count of 0 yields one scan.
- R8: When retrigger is off, a single trigger is served and the block returns to idle. When retrigger is on with count N (0 treated as 1), the block rearms after each burst, serves N triggers and then goes idle.
- R9: Trigger pulses that arrive during the delay, during an acquisition, or in the same clock as the final conversion of a burst are ignored.
- R10: The scan-busy flag is high from a scan start through that scan's last conversion. The acquisition-busy flag is high from the first scan start through the last conversion of the last scan, including the gaps between scans, and is low during the delay.
- R11: An abort returns the block to idle on the next clock. No further strobe appears and both busy flags stay low until a new start.
- R12: All intervals count only clocks with the tick input high. A conversion that is not a scan start happens only in a ticking clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable; interval counters advance only when high |
| trig | input | 1 | Trigger pulse, honoured only when armed |
| start | input | 1 | Arms the sequencer from idle |
| abort | input | 1 | Stops any activity and returns to idle |
| retrig_en | input | 1 | Enables rearming after each burst |
| chan_en | input | NCH | Channel enable mask, bit i for channel i |
| samp_ival | input | IW | Ticks between conversions in a scan |
| scan_ival | input | IW | Ticks between scan starts |
| scan_cnt | input | CW | Scans per trigger |
| dly_cnt | input | DW | Ticks from trigger to first scan |
| retrig_num | input | RW | Number of triggers served in retrigger mode |
| scan_start | output | 1 | Strobe marking the first conversion of a scan |
| conv | output | 1 | Conversion strobe |
| conv_ch | output | CHW | Channel index of the current conversion |
| scan_busy | output | 1 | A scan is in progress |
| acq_busy | output | 1 | An acquisition burst is in progress |
| samp_low | output | 1 | Programmed sample interval is below the floor and is being clamped |

## Verification
The sharpest coincidence is a fresh trigger that lands in the very clock of the final conversion of a burst in retrigger mode. The machine is then still in `SQ_SCAN`, and it must discard the pulse even though it rearms one clock later. The bench computes that cycle from the programmed intervals and pulses the trigger exactly there. It then checks that the conversion count stops at the burst size and that only a later trigger starts the second burst. A second coincidence is the short scan interval. There, scan-timer expiry falls inside a scan, and the launch must wait for the sample timer. The bench judges this from the logged scan-start spacing.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARMED,
        SQ_DELAY,
        SQ_LAUNCH,
        SQ_SCAN,
        SQ_GAP
    } sq_state_t;

endpackage

// File: rtl/seq_tick_timer.sv
// Down-counter that advances on timebase ticks and saturates at zero.
// expire_now is high when the count is already zero or reaches zero this clock.
module seq_tick_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire_now
);

    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && (remain != '0)) begin
            remain <= remain - W'(1);
        end
    end

    assign expire_now = (remain == '0) || ((remain == W'(1)) && tick);

endmodule

// File: rtl/seq_chan_pick.sv
// Finds the lowest enabled channel above a given index (or the lowest overall),
// and for each channel whether any enabled channel lies above it.
module seq_chan_pick #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] en,
    input  logic [CHW-1:0] above,
    input  logic           from_bottom,
    output logic [CHW-1:0] nxt,
    output logic           nxt_vld,
    output logic [NCH-1:0] hi_any
);

    always_comb begin
        nxt     = '0;
        nxt_vld = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (en[i] && (from_bottom || (i > int'(above)))) begin
                nxt     = CHW'(i);
                nxt_vld = 1'b1;
            end
        end
    end

    always_comb begin
        hi_any = '0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = i + 1; j < NCH; j++) begin
                if (en[j]) hi_any[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int IW       = 24,
    parameter int CW       = 24,
    parameter int DW       = 16,
    parameter int RW       = 16,
    parameter int MIN_SAMP = 100,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           trig,
    input  logic           start,
    input  logic           abort,
    input  logic           retrig_en,
    input  logic [NCH-1:0] chan_en,
    input  logic [IW-1:0]  samp_ival,
    input  logic [IW-1:0]  scan_ival,
    input  logic [CW-1:0]  scan_cnt,
    input  logic [DW-1:0]  dly_cnt,
    input  logic [RW-1:0]  retrig_num,
    output logic           scan_start,
    output logic           conv,
    output logic [CHW-1:0] conv_ch,
    output logic           scan_busy,
    output logic           acq_busy,
    output logic           samp_low
);

    sq_state_t      state, nstate;
    logic [CHW-1:0] cur_ch;
    logic [CW-1:0]  scans_left, scans_rem;
    logic [RW-1:0]  trigs_left;
    logic [IW-1:0]  samp_eff;
    logic           accept, arm, do_launch, do_conv, scan_last, more_scans;
    logic           dly_zn, scan_zn, samp_zn, pick_vld;
    logic [CHW-1:0] pick_ch;
    logic [NCH-1:0] hi_any;

    assign samp_low = (samp_ival < IW'(MIN_SAMP));
    assign samp_eff = samp_low ? IW'(MIN_SAMP) : samp_ival;

    seq_tick_timer #(.W(DW)) u_dly_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(accept), .load_val(dly_cnt), .expire_now(dly_zn)
    );

    seq_tick_timer #(.W(IW)) u_scan_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(do_launch), .load_val(scan_ival), .expire_now(scan_zn)
    );

    seq_tick_timer #(.W(IW)) u_samp_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(do_conv), .load_val(samp_eff), .expire_now(samp_zn)
    );

    seq_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .en(chan_en), .above(cur_ch), .from_bottom(do_launch),
        .nxt(pick_ch), .nxt_vld(pick_vld), .hi_any(hi_any)
    );

    // Event decode and next-state logic
    always_comb begin
        arm        = (state == SQ_IDLE) && start && (chan_en != '0);
        accept     = (state == SQ_ARMED) && trig;
        do_launch  = (state == SQ_LAUNCH) ||
                     ((state == SQ_GAP) && scan_zn && samp_zn);
        do_conv    = pick_vld && (do_launch || ((state == SQ_SCAN) && samp_zn));
        scan_last  = do_conv && !hi_any[pick_ch];
        scans_rem  = do_launch ? (scans_left - CW'(1)) : scans_left;
        more_scans = (scans_rem != '0);

        nstate = state;
        unique case (state)
            SQ_IDLE:   if (arm) nstate = SQ_ARMED;
            SQ_ARMED:  if (trig) nstate = (dly_cnt == '0) ? SQ_LAUNCH : SQ_DELAY;
            SQ_DELAY:  if (dly_zn) nstate = SQ_LAUNCH;
            SQ_LAUNCH, SQ_SCAN, SQ_GAP: begin
                if (scan_last) begin
                    if (more_scans)               nstate = SQ_GAP;
                    else if (trigs_left > RW'(1)) nstate = SQ_ARMED;
                    else                          nstate = SQ_IDLE;
                end else if (do_launch) begin
                    nstate = SQ_SCAN;
                end
            end
            default: nstate = SQ_IDLE;
        endcase
        if (abort) nstate = SQ_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nstate;
    end

    // Scan, trigger and channel bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch     <= '0;
            scans_left <= '0;
            trigs_left <= '0;
        end else begin
            if (do_conv) cur_ch <= pick_ch;
            if (accept) begin
                scans_left <= (scan_cnt == '0) ? CW'(1) : scan_cnt;
            end else if (do_launch) begin
                scans_left <= scans_left - CW'(1);
            end
            if (arm) begin
                if (retrig_en && (retrig_num != '0)) trigs_left <= retrig_num;
                else                                 trigs_left <= RW'(1);
            end else if (scan_last && !more_scans && (trigs_left != '0)) begin
                trigs_left <= trigs_left - RW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        scan_start = do_launch;
        conv       = do_conv;
        conv_ch    = pick_ch;
        scan_busy  = do_launch || (state == SQ_LAUNCH) || (state == SQ_SCAN);
        acq_busy   = (state == SQ_LAUNCH) || (state == SQ_SCAN) || (state == SQ_GAP);
    end

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic abort,
    input logic scan_start,
    input logic conv,
    input logic scan_busy,
    input logic acq_busy
);

    assert_start_with_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |-> conv);

    assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv |=> !conv);

    assert_conv_inside_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv |-> scan_busy);

    assert_scan_inside_acq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> acq_busy);

    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!conv && !acq_busy));

    assert_conv_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && !scan_start) |-> tick);

endmodule

bind scan_seq_top scan_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .abort(abort),
    .scan_start(scan_start), .conv(conv),
    .scan_busy(scan_busy), .acq_busy(acq_busy)
);

// File: tb/scan_seq_top_bench.sv
module scan_seq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        tick_half = 1'b0;
    logic        trig = 1'b0, start = 1'b0, abort = 1'b0, retrig_en = 1'b0;
    logic [7:0]  chan_en = '0;
    logic [23:0] samp_ival = 24'd100, scan_ival = 24'd400, scan_cnt = 24'd1;
    logic [15:0] dly_cnt = '0, retrig_num = '0;
    logic        scan_start, conv, scan_busy, acq_busy, samp_low;
    logic [2:0]  conv_ch;

    int n_chk = 0, n_bad = 0, cyc = 0, n_conv = 0, n_ss = 0, tc = 0;
    int conv_cyc [0:255];
    int conv_chs [0:255];
    int ss_cyc   [0:63];

    scan_seq_top u_scan_seq_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .start(start),
        .abort(abort), .retrig_en(retrig_en), .chan_en(chan_en),
        .samp_ival(samp_ival), .scan_ival(scan_ival), .scan_cnt(scan_cnt),
        .dly_cnt(dly_cnt), .retrig_num(retrig_num), .scan_start(scan_start),
        .conv(conv), .conv_ch(conv_ch), .scan_busy(scan_busy),
        .acq_busy(acq_busy), .samp_low(samp_low)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tick <= tick_half ? ~tick : 1'b1;
    end

    always @(negedge clk) begin
        if (conv && n_conv < 256) begin
            conv_cyc[n_conv] = cyc;
            conv_chs[n_conv] = int'(conv_ch);
            n_conv = n_conv + 1;
        end
        if (scan_start && n_ss < 64) begin
            ss_cyc[n_ss] = cyc;
            n_ss = n_ss + 1;
        end
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic conv_at(input string req, input int idx, input int exp_cyc, input int exp_ch);
        eq({req, " conv cycle"}, (idx < n_conv) ? conv_cyc[idx] : -1, exp_cyc);
        eq({req, " conv channel"}, (idx < n_conv) ? conv_chs[idx] : -1, exp_ch);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_trig();
        @(negedge clk); trig = 1'b1; tc = cyc;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic trig_at(input int c);
        wait_until(c); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic t_reset();
        int base;
        @(negedge clk);
        eq("R1 reset scan_start", int'(scan_start), 0);
        eq("R1 reset conv", int'(conv), 0);
        eq("R1 reset busy flags", int'(scan_busy) + int'(acq_busy), 0);
        base = n_conv;
        chan_en = 8'h01;
        do_trig();
        repeat (300) @(negedge clk);
        eq("R1 trigger while idle", n_conv - base, 0);
    endtask

    task automatic t_basic();
        int base, bss;
        int chs [3] = '{0, 2, 5};
        chan_en = 8'b0010_0101; samp_ival = 24'd100; scan_ival = 24'd400;
        scan_cnt = 24'd3; dly_cnt = '0; retrig_en = 1'b0;
        eq("R5 no clamp at 100", int'(samp_low), 0);
        do_start();
        base = n_conv; bss = n_ss;
        do_trig();
        trig_at(tc + 150);                       // R9 trigger mid-acquisition
        wait_until(tc + 251);
        eq("R10 acq_busy in gap", int'(acq_busy), 1);
        eq("R10 scan_busy in gap", int'(scan_busy), 0);
        wait_until(tc + 1001);
        eq("R10 scan_busy at last conv", int'(scan_busy), 1);
        @(negedge clk);
        eq("R10 acq_busy after last conv", int'(acq_busy), 0);
        repeat (400) @(negedge clk);
        eq("R7 R9 conversions per trigger", n_conv - base, 9);
        for (int s = 0; s < 3; s++) begin
            eq("R2 R6 scan start cycle", (bss + s < n_ss) ? ss_cyc[bss + s] : -1, tc + 1 + s * 400);
            for (int i = 0; i < 3; i++)
                conv_at("R4 ascending order", base + s * 3 + i, tc + 1 + s * 400 + i * 100, chs[i]);
        end
        base = n_conv;
        do_trig();
        repeat (200) @(negedge clk);
        eq("R8 single trigger then idle", n_conv - base, 0);
    endtask

    task automatic t_short_interval();
        int base, bss;
        chan_en = 8'b1100_0010; scan_ival = 24'd50; scan_cnt = 24'd2;
        do_start();
        base = n_conv; bss = n_ss;
        do_trig();
        repeat (800) @(negedge clk);
        eq("R6 scans run", n_conv - base, 6);
        eq("R6 short interval spacing",
           (bss + 1 < n_ss) ? ss_cyc[bss + 1] - ss_cyc[bss] : -1, 300);
        conv_at("R6 second scan first conv", base + 3, tc + 301, 1);
        conv_at("R4 top channel", base + 5, tc + 501, 7);
    endtask

    task automatic t_delay();
        int base;
        chan_en = 8'b0000_1000; scan_ival = 24'd200; scan_cnt = 24'd2; dly_cnt = 16'd37;
        do_start();
        base = n_conv;
        do_trig();
        trig_at(tc + 10);                        // R9 trigger during delay
        wait_until(tc + 20);
        eq("R10 acq_busy low during delay", int'(acq_busy), 0);
        repeat (500) @(negedge clk);
        eq("R3 R9 conversion count", n_conv - base, 2);
        conv_at("R3 delayed first scan", base, tc + 38, 3);
        conv_at("R3 second scan", base + 1, tc + 238, 3);
        dly_cnt = '0;
    endtask

    task automatic t_retrig();
        int base, t1;
        chan_en = 8'b0000_0011; scan_ival = 24'd300; scan_cnt = 24'd2;
        retrig_en = 1'b1; retrig_num = 16'd2;
        do_start();
        base = n_conv;
        do_trig(); t1 = tc;
        trig_at(t1 + 401);                       // R9 trigger on the final conversion
        wait_until(t1 + 420);
        eq("R8 acq_busy low while rearmed", int'(acq_busy), 0);
        repeat (300) @(negedge clk);
        eq("R9 trigger at final conversion ignored", n_conv - base, 4);
        conv_at("R8 first burst last", base + 3, t1 + 401, 1);
        do_trig();
        repeat (600) @(negedge clk);
        eq("R8 second burst", n_conv - base, 8);
        conv_at("R8 second burst first", base + 4, tc + 1, 0);
        do_trig();
        repeat (600) @(negedge clk);
        eq("R8 idle after retrigger count", n_conv - base, 8);
        retrig_en = 1'b0; retrig_num = '0;
    endtask

    task automatic t_clamp();
        int base;
        chan_en = 8'b0001_0100; samp_ival = 24'd10; scan_ival = 24'd0; scan_cnt = 24'd0;
        @(negedge clk);
        eq("R5 clamp flag", int'(samp_low), 1);
        do_start();
        base = n_conv;
        do_trig();
        repeat (400) @(negedge clk);
        eq("R7 zero count gives one scan", n_conv - base, 2);
        conv_at("R5 clamped spacing", base + 1, tc + 101, 4);
        samp_ival = 24'd100;
    endtask

    task automatic t_tick();
        int base, d0;
        chan_en = 8'b0000_0111; scan_cnt = 24'd1; scan_ival = 24'd0;
        tick_half = 1'b1;
        do_start();
        base = n_conv;
        do_trig();
        repeat (800) @(negedge clk);
        eq("R12 conversions", n_conv - base, 3);
        d0 = (base + 1 < n_conv) ? conv_cyc[base + 1] - conv_cyc[base] : -1;
        chk(d0 == 199 || d0 == 200, "R12 first spacing", d0, 200);
        eq("R12 tick-paced spacing",
           (base + 2 < n_conv) ? conv_cyc[base + 2] - conv_cyc[base + 1] : -1, 200);
        tick_half = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_abort();
        int base;
        chan_en = 8'b0000_1111; scan_ival = 24'd500; scan_cnt = 24'd5;
        do_start();
        base = n_conv;
        do_trig();
        wait_until(tc + 150);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        eq("R11 acq_busy after abort", int'(acq_busy), 0);
        repeat (700) @(negedge clk);
        eq("R11 no conversion after abort", n_conv - base, 2);
        do_trig();
        repeat (200) @(negedge clk);
        eq("R11 idle until new start", n_conv - base, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_short_interval();
        t_delay();
        t_retrig();
        t_clamp();
        t_tick();
        t_abort();
        summary_and_end();
    end

endmodule